// File: doc/BRIEF.md
# Wake-up Event Status Register

This block gathers the wake-up causes of a power-down controller into one 32-bit read-only status word. Four sources feed sticky flags: a wake-up pin event, a real-time-clock alarm, an analog comparator alarm and a low-power UART match alarm. Each source arrives as a single-cycle pulse. A flag is set only while the system is in backup mode. It stays set until software reads the word.

A separate debouncer strobe captures a snapshot of ten wake-up input levels. Each level is masked by its own enable bit. The snapshot lets software see which inputs were active when the wake-up fired. Reading the word at its offset returns the data in the same cycle. The read also clears both the sticky flags and the snapshot on the next clock edge. An event that lands in the read cycle is kept for the following read.

Top module: `wake_status_top`

## Requirements
- R1: After a synchronous active-high reset, every bit of the status word reads 0.
- R2: In backup mode, a pulse sets a fixed bit of the word: the wake-up pin sets bit 0, the clock alarm sets bit 5, the comparator alarm sets bit 6 and the UART match alarm sets bit 7. The bit is readable from the cycle after the pulse.
- R3: A set flag stays 1 through idle cycles and further pulses until the word is read.
- R4: A read at the status offset clears bits 0, 5, 6, 7 and 16 to 25 at the next clock edge. An immediate second read therefore returns 0.
- R5: A flag pulse that coincides with a read is not lost. That read returns the old value, and the next read shows the flag set.
- R6: Outside backup mode, flag pulses and debouncer strobes change nothing that a later read can see.
- R7: A debouncer strobe in backup mode loads bit 16+i with wake-up level i AND enable i, for i from 0 to 9.
- R8: A later strobe overwrites the snapshot. It does not merge with the earlier one.
- R9: A strobe in the same cycle as a read wins over the clear. That read returns the old snapshot, and the next read returns the new one.
- R10: Bits 1 to 4, 8 to 15 and 26 to 31 always read 0.
- R11: Only a read strobe with address 0x08 returns data and clears state. A read at any other address returns 0 and clears nothing.
- R12: Read data is valid in the same cycle as the strobe. It is 0 in any cycle without a matching strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inBackup | input | 1 | High while the system is in backup mode |
| pinWakePulse | input | 1 | Single-cycle wake-up pin event |
| rtcAlarmPulse | input | 1 | Single-cycle real-time-clock alarm |
| cmpAlarmPulse | input | 1 | Single-cycle analog comparator alarm |
| uartMatchPulse | input | 1 | Single-cycle low-power UART match alarm |
| debounceTrig | input | 1 | Debouncer wake-up trigger strobe |
| wakeLevel | input | 10 | Current wake-up input levels |
| wakeEnable | input | 10 | Per-input enable bits |
| rdStrobe | input | 1 | Single-cycle read request |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 32 | Status word, combinational |

## Verification
A flag pulse or a debouncer strobe applied in one cycle is captured at the next rising edge. It is therefore due on the read data in any read strobe cycle after that edge. The read data itself is combinational, so it is due in the same cycle as the strobe. The clear that a read causes is seen by a read one cycle later. The bench drives every input just after a falling edge and samples the read data 2 ns later, in the same low phase. The scoreboard compares each read strobe with the word its own model predicted at the moment the read was issued, and the model applies clear before set and load.

// File: rtl/wake_status_pkg.sv
package wake_status_pkg;

  localparam int STICKY_N = 4;

  // sticky flag index -> bit position in the status word
  // index 0 pin, 1 clock alarm, 2 comparator, 3 UART match
  localparam int STICKY_POS [STICKY_N] = '{0, 5, 6, 7};

  typedef struct packed {
    logic [STICKY_N-1:0] setSticky;
    logic                clrSticky;
    logic                loadSnap;
    logic                clrSnap;
    logic                rdHit;
  } wake_strb_t;

endpackage

// File: rtl/wake_status_ctrl.sv
module wake_status_ctrl
  import wake_status_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int STATUS_OFFSET = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inBackup,
  input  logic       pinWakePulse,
  input  logic       rtcAlarmPulse,
  input  logic       cmpAlarmPulse,
  input  logic       uartMatchPulse,
  input  logic       debounceTrig,
  input  logic       rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output wake_strb_t strb
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STATUS_OFFSET);

  logic rdHit;
  logic [STICKY_N-1:0] rawEvents;

  assign rdHit     = rdStrobe && (rdAddr == HIT_ADDR);
  assign rawEvents = {uartMatchPulse, cmpAlarmPulse, rtcAlarmPulse, pinWakePulse};

  always_comb begin
    strb           = '0;
    strb.rdHit     = rdHit;
    strb.clrSticky = rdHit;
    strb.clrSnap   = rdHit;
    strb.setSticky = inBackup ? rawEvents : '0;
    strb.loadSnap  = inBackup && debounceTrig;
  end

  // a read strobe at a foreign offset must never produce a clear
  assert_foreign_no_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && rdAddr != HIT_ADDR) |-> !(strb.clrSticky || strb.clrSnap));

endmodule

// File: rtl/wake_status_dp.sv
module wake_status_dp
  import wake_status_pkg::*;
#(
  parameter int NUM_IN   = 10,
  parameter int SNAP_LSB = 16,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  wake_strb_t        strb,
  input  logic [NUM_IN-1:0] level,
  input  logic [NUM_IN-1:0] enable,
  output logic [DATA_W-1:0] rdData
);

  logic [STICKY_N-1:0] stickyQ;
  logic [NUM_IN-1:0]   snapQ;
  logic [DATA_W-1:0]   word;

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)                    stickyQ[i] <= 1'b0;
      else if (strb.setSticky[i]) stickyQ[i] <= 1'b1;
      else if (strb.clrSticky)    stickyQ[i] <= 1'b0;
    end

    assert_event_kept_R5: assert property (@(posedge clk) disable iff (rst)
      strb.setSticky[i] |=> stickyQ[i]);

    assert_flag_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (stickyQ[i] && !strb.clrSticky) |=> stickyQ[i]);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
      (!stickyQ[i] && !strb.setSticky[i]) |=> !stickyQ[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)               snapQ <= '0;
    else if (strb.loadSnap) snapQ <= level & enable;
    else if (strb.clrSnap)  snapQ <= '0;
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < STICKY_N; i++) word[STICKY_POS[i]] = stickyQ[i];
    word[SNAP_LSB +: NUM_IN] = snapQ;
    rdData = strb.rdHit ? word : '0;
  end

  assert_read_clears_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.clrSticky && strb.setSticky == '0) |=> stickyQ == '0);

  assert_read_clears_snap_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.clrSnap && !strb.loadSnap) |=> snapQ == '0);

  assert_snap_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (!strb.loadSnap && !strb.clrSnap) |=> $stable(snapQ));

endmodule

// File: rtl/wake_status_top.sv
module wake_status_top
  import wake_status_pkg::*;
#(
  parameter int NUM_IN        = 10,
  parameter int SNAP_LSB      = 16,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int STATUS_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inBackup,
  input  logic              pinWakePulse,
  input  logic              rtcAlarmPulse,
  input  logic              cmpAlarmPulse,
  input  logic              uartMatchPulse,
  input  logic              debounceTrig,
  input  logic [NUM_IN-1:0] wakeLevel,
  input  logic [NUM_IN-1:0] wakeEnable,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int SNAP_TOP = SNAP_LSB + NUM_IN;

  wake_strb_t strb;

  wake_status_ctrl #(
    .ADDR_W(ADDR_W),
    .STATUS_OFFSET(STATUS_OFFSET)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .inBackup(inBackup),
    .pinWakePulse(pinWakePulse),
    .rtcAlarmPulse(rtcAlarmPulse),
    .cmpAlarmPulse(cmpAlarmPulse),
    .uartMatchPulse(uartMatchPulse),
    .debounceTrig(debounceTrig),
    .rdStrobe(rdStrobe),
    .rdAddr(rdAddr),
    .strb(strb)
  );

  wake_status_dp #(
    .NUM_IN(NUM_IN),
    .SNAP_LSB(SNAP_LSB),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .strb(strb),
    .level(wakeLevel),
    .enable(wakeEnable),
    .rdData(rdData)
  );

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    rdData[4:1] == '0 && rdData[15:8] == '0 && rdData[DATA_W-1:SNAP_TOP] == '0);

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !rdStrobe |-> rdData == '0);

  assert_foreign_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && rdAddr != ADDR_W'(STATUS_OFFSET)) |-> rdData == '0);

  assert_snap_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (debounceTrig && inBackup) |=> (u_dp.snapQ & ~$past(wakeEnable)) == '0);

endmodule

// File: tb/wake_status_top_tb.sv
module wake_status_top_tb;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inBackup = 1'b0;
  logic        pinWakePulse = 1'b0, rtcAlarmPulse = 1'b0;
  logic        cmpAlarmPulse = 1'b0, uartMatchPulse = 1'b0;
  logic        debounceTrig = 1'b0;
  logic [9:0]  wakeLevel = '0, wakeEnable = '0;
  logic        rdStrobe = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  exp_t expQ[$];
  logic [3:0] mSticky = '0;   // {uart, cmp, rtc, pin}
  logic [9:0] mSnap = '0;

  always #5 clk = ~clk;

  wake_status_top u_dut (
    .clk(clk), .rst(rst), .inBackup(inBackup),
    .pinWakePulse(pinWakePulse), .rtcAlarmPulse(rtcAlarmPulse),
    .cmpAlarmPulse(cmpAlarmPulse), .uartMatchPulse(uartMatchPulse),
    .debounceTrig(debounceTrig), .wakeLevel(wakeLevel), .wakeEnable(wakeEnable),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [31:0] modelWord();
    return {6'b0, mSnap, 8'b0, mSticky[3:1], 4'b0, mSticky[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; evt = {uart, cmp, rtc, pin}
  task automatic step(input logic [3:0] evt, input logic trig, input logic rd,
                      input logic [7:0] addr, input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    {uartMatchPulse, cmpAlarmPulse, rtcAlarmPulse, pinWakePulse} = evt;
    debounceTrig = trig;
    rdStrobe = rd;
    rdAddr = addr;
    hit = rd && (addr == 8'h08);
    if (rd) begin
      e.data = hit ? modelWord() : 32'h0;
      e.tag  = tag;
      expQ.push_back(e);
    end
    if (hit) begin
      mSticky = '0;
      mSnap = '0;
    end
    if (inBackup) begin
      mSticky = mSticky | evt;
      if (trig) mSnap = wakeLevel & wakeEnable;
    end
    @(posedge clk);
    #1;
    {uartMatchPulse, cmpAlarmPulse, rtcAlarmPulse, pinWakePulse} = '0;
    debounceTrig = 1'b0;
    rdStrobe = 1'b0;
  endtask

  task automatic rd(input string tag);
    step(4'b0, 1'b0, 1'b1, 8'h08, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rdStrobe) begin
        if (expQ.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R12: unexpected read, actual=%08h expected=none", rdData);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(e.tag, rdData, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd("R1 reset state");

    inBackup = 1'b1;
    step(4'b0001, 1'b0, 1'b0, 8'h08, "");
    rd("R2 pin bit0");
    rd("R4 cleared after read");

    step(4'b0010, 1'b0, 1'b0, 8'h08, "");
    step(4'b0100, 1'b0, 1'b0, 8'h08, "");
    step(4'b0010, 1'b0, 1'b0, 8'h08, "");
    step(4'b1000, 1'b0, 1'b0, 8'h08, "");
    repeat (4) @(negedge clk);
    #2;
    check("R12 idle output zero", rdData, 32'h0);
    rd("R3 R2 alarm bits 5,6,7 held");
    rd("R4 second read zero");

    inBackup = 1'b0;
    wakeLevel = 10'h3FF;
    wakeEnable = 10'h3FF;
    step(4'b1111, 1'b1, 1'b0, 8'h08, "");
    rd("R6 ignored outside backup");

    inBackup = 1'b1;
    step(4'b0010, 1'b0, 1'b1, 8'h08, "R5 read with coincident event");
    rd("R5 coincident event kept");

    wakeLevel = 10'h3FF;
    wakeEnable = 10'h2A5;
    step(4'b0, 1'b1, 1'b0, 8'h08, "");
    rd("R7 snapshot masked");
    rd("R4 snapshot cleared");

    wakeLevel = 10'h0F0;
    wakeEnable = 10'h3FF;
    step(4'b0, 1'b1, 1'b0, 8'h08, "");
    wakeLevel = 10'h00F;
    step(4'b0, 1'b1, 1'b0, 8'h08, "");
    rd("R8 snapshot overwritten");

    wakeLevel = 10'h155;
    step(4'b0, 1'b1, 1'b0, 8'h08, "");
    wakeLevel = 10'h2AA;
    step(4'b0, 1'b1, 1'b1, 8'h08, "R9 read returns old snapshot");
    rd("R9 new snapshot kept");

    step(4'b0001, 1'b0, 1'b0, 8'h08, "");
    step(4'b0, 1'b0, 1'b1, 8'h04, "R11 foreign offset zero");
    rd("R11 nothing cleared by foreign read");

    wakeLevel = 10'h3FF;
    wakeEnable = 10'h3FF;
    step(4'b1111, 1'b1, 1'b0, 8'h08, "");
    step(4'b0, 1'b0, 1'b1, 8'h08, "R10 reserved bits zero");
    check("R10 model word", modelWord(), 32'h0);

    repeat (3) @(negedge clk);
    wait (expQ.size() == 0);
    #3;
    finishRun();
  end

endmodule